// File: doc/BRIEF.md
# Multi-Source Interrupt Controller

This block gathers thirty-two interrupt request lines and turns them into two processor interrupt lines, one normal and one critical. Each line passes through a two-stage synchronizer. A per-line sense type (edge or level) and a per-line polarity then decide when the line counts as an event. Events are captured in a sticky status register. An enable register gates the captured bits, and a per-line class bit steers each enabled bit to one of the two outputs.

Software programs and services the controller over a simple word-addressed register bus with 32-bit data, a write strobe and a read strobe. A read-only view of status AND enable lets the handler pick the next line to serve. The handler clears a served line by writing a one to its status bit. A level-sensed line stays set for as long as its input is still active.

Top module: `irq_ctrl`

## Requirements
- R1: Source n (0..31) occupies bit 31-n of every per-source register, so source 0 is the most significant bit.
- R2: Word offsets: 0x0 status, 0x2 enable, 0x3 class, 0x4 polarity, 0x5 sense type, 0x6 masked status. Offsets 0x7 and 0x8 read as zero. Read data appears on the output in the cycle after the read strobe and holds until the next read.
- R3: A sense-type bit of 1 selects edge detection and 0 selects level detection. A polarity bit of 1 selects a rising edge or an active-high level, and 0 selects a falling edge or an active-low level.
- R4: Writing status clears each bit written as 1 and leaves each bit written as 0 unchanged. No status bit falls except through such a write.
- R5: For a level-sensed source whose input is still active, a clear has no effect, whether the source is enabled or not.
- R6: Masked status reads as status AND enable. Status bits capture events while the source is disabled, so enabling a source whose bit is already set raises an output at once.
- R7: A class bit of 0 routes the source to the normal output and 1 routes it to the critical output. Each output is the OR of the enabled, pending sources of its class.
- R8: When a set event and a software clear hit the same status bit in the same cycle, the bit stays set.
- R9: Reset clears enable, class, polarity, sense type and status. Both outputs are low while the enable register is zero.
- R10: Writes to the masked-status offset change no register.
- R11: An input change is captured in status on the third rising clock edge after it, because of the two synchronizer flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt request lines, bit 31-n is source n |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_norm_o | output | 1 | Normal interrupt output |
| irq_crit_o | output | 1 | Critical interrupt output |

## Verification
A table covers all four combinations of sense type and polarity, each with both input directions. For every entry the bench first records the status after a clear and then the status after the input moves. Edge modes that see the wrong direction therefore show up as zero, and level modes that hold their active value show up as a clear that did not take. Directed patterns use the two extreme bit positions to expose a reversed bit order. They also drive an edge event into the same cycle as a clear to check the priority rule. The routing test holds a level line active while the enable and class bits are toggled, which separates capture from gating and from output steering.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC   = 32;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        OFF_STAT = 4'h0,
        OFF_EN   = 4'h2,
        OFF_CLS  = 4'h3,
        OFF_POL  = 4'h4,
        OFF_TRIG = 4'h5,
        OFF_MSK  = 4'h6,
        OFF_VEC  = 4'h7,
        OFF_VCFG = 4'h8
    } reg_off_e;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] cls;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] trig;
    } cfg_t;

    // bit position carrying source n
    function automatic int src_pos(input int n);
        return NSRC - 1 - n;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_sense.sv
module irq_sense #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] trig_i,
    output logic [N-1:0] set_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= line_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic active, edge_hit;
        always_comb begin
            active   = pol_i[g] ? line_i[g] : ~line_i[g];
            edge_hit = pol_i[g] ? (line_i[g] & ~prev_q[g]) : (~line_i[g] & prev_q[g]);
            set_o[g] = trig_i[g] ? edge_hit : active;
        end
    end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int N = 32
) (
    input  logic [N-1:0] masked_i,
    input  logic [N-1:0] cls_i,
    output logic         norm_o,
    output logic         crit_o
);
    always_comb begin
        norm_o = |(masked_i & ~cls_i);
        crit_o = |(masked_i & cls_i);
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_norm_o,
    output logic              irq_crit_o
);
    cfg_t            cfg_q;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] line_s;
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic [NSRC-1:0] masked;

    irq_sync #(.W(NSRC), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (line_s)
    );

    irq_sense #(.N(NSRC)) u_sense (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_s),
        .pol_i  (cfg_q.pol),
        .trig_i (cfg_q.trig),
        .set_o  (set_v)
    );

    assign clr_v  = (bus_we && bus_addr == OFF_STAT) ? bus_wdata[NSRC-1:0] : '0;
    assign masked = status_q & cfg_q.en;

    // configuration and status; a set event overrides a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            status_q <= '0;
        end else begin
            if (bus_we) begin
                case (bus_addr)
                    OFF_EN:   cfg_q.en   <= bus_wdata[NSRC-1:0];
                    OFF_CLS:  cfg_q.cls  <= bus_wdata[NSRC-1:0];
                    OFF_POL:  cfg_q.pol  <= bus_wdata[NSRC-1:0];
                    OFF_TRIG: cfg_q.trig <= bus_wdata[NSRC-1:0];
                    default:  ;
                endcase
            end
            status_q <= (status_q & ~clr_v) | set_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            case (bus_addr)
                OFF_STAT: bus_rdata <= DATA_W'(status_q);
                OFF_EN:   bus_rdata <= DATA_W'(cfg_q.en);
                OFF_CLS:  bus_rdata <= DATA_W'(cfg_q.cls);
                OFF_POL:  bus_rdata <= DATA_W'(cfg_q.pol);
                OFF_TRIG: bus_rdata <= DATA_W'(cfg_q.trig);
                OFF_MSK:  bus_rdata <= DATA_W'(masked);
                default:  bus_rdata <= '0;
            endcase
        end
    end

    irq_route #(.N(NSRC)) u_route (
        .masked_i (masked),
        .cls_i    (cfg_q.cls),
        .norm_o   (irq_norm_o),
        .crit_o   (irq_crit_o)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NSRC-1:0]   status_q,
    input logic [NSRC-1:0]   enable_q,
    input logic [NSRC-1:0]   class_q,
    input logic              irq_norm_o,
    input logic              irq_crit_o
);
    // R4: status bits fall only through a write to the status offset
    assert_no_drop_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFF_STAT) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R2: read data holds when no read strobe is given
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));

    // R2: reserved offsets return zero
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_re && (bus_addr == OFF_VEC || bus_addr == OFF_VCFG)) |=> bus_rdata == '0);

    // R10: masked-status write leaves enable and class untouched
    assert_msk_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_MSK) |=> ($stable(enable_q) && $stable(class_q)));

    // R9: configuration is zero right after reset
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (enable_q == '0 && class_q == '0 && status_q == '0));

    // R9: no output while nothing is enabled
    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        (enable_q == '0) |-> (!irq_norm_o && !irq_crit_o));

    // R7: each output follows its class
    assert_route_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_norm_o == |(status_q & enable_q & ~class_q)) &&
        (irq_crit_o == |(status_q & enable_q & class_q)));
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .status_q   (status_q),
    .enable_q   (cfg_q.en),
    .class_q    (cfg_q.cls),
    .irq_norm_o (irq_norm_o),
    .irq_crit_o (irq_crit_o)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_norm_o, irq_crit_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_ctrl u_dut (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .irq_norm_o(irq_norm_o), .irq_crit_o(irq_crit_o)
    );

    // {sense_edge, pol, v0, v1, status_after_clear, status_final}
    localparam logic [5:0] VEC [8] = '{
        6'b1_1_0_1_0_1, 6'b1_1_1_0_0_0, 6'b1_0_1_0_0_1, 6'b1_0_0_1_0_0,
        6'b0_1_0_1_0_1, 6'b0_1_1_0_1_1, 6'b0_0_1_0_0_1, 6'b0_0_0_1_1_1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: reset values
        rd(4'h2, r); chk("R9 enable reset", r, 32'h0);
        rd(4'h3, r); chk("R9 class reset", r, 32'h0);
        rd(4'h4, r); chk("R9 polarity reset", r, 32'h0);
        rd(4'h5, r); chk("R9 sense reset", r, 32'h0);
        chk("R9 outputs low", {30'h0, irq_norm_o, irq_crit_o}, 32'h0);
        // R2: reserved offsets
        rd(4'h7, r); chk("R2 offset 7 zero", r, 32'h0);
        rd(4'h8, r); chk("R2 offset 8 zero", r, 32'h0);

        // baseline: active-high level everywhere, status cleared
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h0, 32'hFFFF_FFFF);
        idle(5);
        rd(4'h0, r); chk("R4 clear all", r, 32'h0);

        // R3 table walk, R5 level clear
        for (int i = 0; i < 8; i++) begin
            int pos;
            logic [5:0] v;
            v = VEC[i];
            pos = 31 - (3 * i + 2);
            src_i[pos] = v[3];
            idle(5);
            wr(4'h5, 32'h1 << pos & {32{v[5]}});
            wr(4'h4, ~(32'h1 << pos) | ({31'h0, v[4]} << pos));
            idle(5);
            wr(4'h0, 32'hFFFF_FFFF);
            idle(5);
            rd(4'h0, r); chk($sformatf("R3/R5 vec%0d after clear", i), r, {31'h0, v[1]} << pos);
            src_i[pos] = v[2];
            idle(5);
            rd(4'h0, r); chk($sformatf("R3 vec%0d final", i), r, {31'h0, v[0]} << pos);
            src_i = '0;
            idle(5);
            wr(4'h5, 32'h0);
            wr(4'h4, 32'hFFFF_FFFF);
            wr(4'h0, 32'hFFFF_FFFF);
            idle(2);
        end

        // R1: extreme sources
        src_i = 32'h8000_0001;
        idle(5);
        rd(4'h0, r); chk("R1 source 0 and 31 bits", r, 32'h8000_0001);
        src_i = '0;
        idle(5);
        wr(4'h0, 32'hFFFF_FFFF);

        // R6/R7: capture while disabled, then gate and route (source 4 = bit 27)
        src_i[27] = 1'b1;
        idle(5);
        rd(4'h6, r); chk("R6 masked zero when disabled", r, 32'h0);
        chk("R6 no output when disabled", {31'h0, irq_norm_o}, 32'h0);
        wr(4'h2, 32'h0800_0000);
        chk("R6 immediate normal output", {30'h0, irq_norm_o, irq_crit_o}, 32'h2);
        rd(4'h6, r); chk("R6 masked status", r, 32'h0800_0000);
        wr(4'h3, 32'h0800_0000);
        chk("R7 critical routing", {30'h0, irq_norm_o, irq_crit_o}, 32'h1);
        // R10: masked offset write ignored
        wr(4'h6, 32'h0);
        rd(4'h2, r); chk("R10 enable kept", r, 32'h0800_0000);
        rd(4'h6, r); chk("R10 masked kept", r, 32'h0800_0000);
        // R5: disabled level source with input active
        wr(4'h2, 32'h0);
        wr(4'h0, 32'h0800_0000);
        rd(4'h0, r); chk("R5 level clear blocked while disabled", r, 32'h0800_0000);
        src_i[27] = 1'b0;
        idle(5);
        wr(4'h0, 32'h0800_0000);
        rd(4'h0, r); chk("R5 clear after release", r, 32'h0);
        wr(4'h3, 32'h0);

        // R4: write-one-to-clear selectivity on edge sources (bits 23, 22)
        wr(4'h5, 32'h00C0_0000);
        src_i[23] = 1'b1; src_i[22] = 1'b1;
        idle(5);
        wr(4'h0, 32'h0);
        rd(4'h0, r); chk("R4 zero write keeps bits", r, 32'h00C0_0000);
        wr(4'h0, 32'h0080_0000);
        rd(4'h0, r); chk("R4 single clear", r, 32'h0040_0000);
        src_i = '0;
        idle(5);
        wr(4'h0, 32'hFFFF_FFFF);

        // R8/R11: rising edge on bit 19 meets a clear in the capture cycle
        wr(4'h5, 32'h0008_0000);
        @(negedge clk);
        src_i[19] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = 4'h0; bus_wdata = 32'h0008_0000; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        rd(4'h0, r); chk("R8 set wins over clear, R11 third-edge capture", r, 32'h0008_0000);
        wr(4'h0, 32'h0008_0000);
        rd(4'h0, r); chk("R4 edge bit cleared", r, 32'h0);
        rd(4'h5, r); chk("R2 sense readback", r, 32'h0008_0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule